// File: doc/BRIEF.md
# Serial LED Shift-Chain Controller

This block drives a chain of external shift registers whose parallel outputs light status LEDs. It divides the core clock into a slow shift clock, presents one serial data bit for each shift-clock period, and raises a latch strobe once the whole chain has been shifted. The external latch then copies the shifted pattern onto the LEDs. Frames repeat back to back for as long as the block is enabled.

Each frame is built from several segments of variable length. It starts with a programmable user header, continues with a pre-formatted status field from every enabled port with a non-zero length, adds an optional 17-bit debug word, and ends with a programmable user trailer. Every segment leaves least significant bit first. An output polarity bit makes the block suit both active-high and active-low LEDs. Configuration is written through a single write-enable/address/data port. The two user data words can be written whole or changed bitwise through set and clear addresses.

Top module: `led_chain_ctrl`

## Requirements
- R1: Each half of the shift-clock period lasts max(PHASE,1) x UNIT core clocks, where UNIT is a parameter (default 64), so the full period is twice that. PHASE is 7 bits wide and resets to 4.
- R2: Serial data changes only when the shift clock falls or when a new frame begins, so it is stable at every rising edge of the shift clock. Every segment leaves LSB first.
- R3: A frame carries the header, then the field of each enabled port with a non-zero length in ascending port order, then the debug word, then the trailer. A port field sends bits 0 to len-1 of that port's status.
- R4: A header or trailer count above 32 acts as 32, and a count of 0 leaves its segment out. A port length above 6 acts as 6.
- R5: The 17-bit debug word is part of the frame only while the debug-enable bit is 1.
- R6: With polarity 1 every serial data bit is inverted. With polarity 0 the bits are sent unchanged.
- R7: A write to a data address replaces the user word. A write to a set address ORs the write data into it. A write to a clear address clears the bits that are 1 in the write data.
- R8: Register map (address: field): 0 enable[0]; 1 phase[6:0]; 2 polarity[0]; 3 debug enable[0]; 4 port enable[7:0], bit n for port n; 5 header count[5:0]; 6 trailer count[5:0]; 8/9/10 header word write/set/clear; 12/13/14 trailer word write/set/clear. Writes to any other address have no effect. Port n takes its status from port_stat[6n+5:6n] and its length from port_len[3n+2:3n].
- R9: All configuration, the port inputs and the debug word are sampled when a frame begins. A change made during a frame does not alter that frame.
- R10: After the last bit the latch strobe is high for one full shift-clock period, during which the shift clock stays low. The next frame begins in the cycle the strobe falls.
- R11: While disabled, the shift clock and the latch are low and the serial data rests at the polarity level. Enabling the block starts a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| port_stat | input | 48 | Pre-formatted status bits, 6 per port |
| port_len | input | 24 | Status field length, 3 bits per port |
| dbg_word | input | 17 | Debug word |
| led_sclk | output | 1 | Shift clock to the LED chain |
| led_sdata | output | 1 | Serial data to the LED chain |
| led_latch | output | 1 | Latch strobe to the LED chain |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of a frame. Frame-start sampling makes such a write invisible until the next latch. The bench syncs to a latch edge, starts collecting bits, and rewrites the header count about thirty cycles later, while the header is still shifting. It then requires the collected frame to match the old configuration. A deterministic sweep of twelve configurations drives the segment-skipping logic through empty headers, clamped counts, disabled and zero-length ports, and both polarities.

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl #(
  parameter int NPORT = 8,
  parameter int PSW   = 6,
  parameter int UDW   = 32,
  parameter int DBGW  = 17,
  parameter int PHW   = 7,
  parameter int UNIT  = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [3:0]                   cfg_addr,
  input  logic [UDW-1:0]               cfg_wdata,
  input  logic [NPORT*PSW-1:0]         port_stat,
  input  logic [NPORT*$clog2(PSW+1)-1:0] port_len,
  input  logic [DBGW-1:0]              dbg_word,
  output logic                         led_sclk,
  output logic                         led_sdata,
  output logic                         led_latch
);
  localparam int LW = $clog2(PSW + 1);
  localparam int CW = $clog2(UDW + 1);
  localparam int IW = $clog2(UDW > DBGW ? UDW : DBGW);
  localparam int PW = NPORT > 1 ? $clog2(NPORT) : 1;
  localparam int HW = PHW + $clog2(UNIT) + 1;

  localparam logic [2:0] SEG_HEAD = 3'd0, SEG_PORT = 3'd1, SEG_DBG = 3'd2,
                         SEG_TAIL = 3'd3, SEG_LATCH = 3'd4;

  logic             en_r, pol_r, dbgen_r;
  logic [PHW-1:0]   phase_r;
  logic [NPORT-1:0] pen_r;
  logic [CW-1:0]    hcnt_r, tcnt_r;
  logic [UDW-1:0]   hdat_r, tdat_r;

  function automatic logic [CW-1:0] clamp_cnt(input logic [CW-1:0] v);
    return (v > CW'(UDW)) ? CW'(UDW) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= 1'b0; pol_r <= 1'b0; dbgen_r <= 1'b0; phase_r <= PHW'(4);
      pen_r <= '0; hcnt_r <= '0; tcnt_r <= '0; hdat_r <= '0; tdat_r <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0:  en_r    <= cfg_wdata[0];
        4'd1:  phase_r <= cfg_wdata[PHW-1:0];
        4'd2:  pol_r   <= cfg_wdata[0];
        4'd3:  dbgen_r <= cfg_wdata[0];
        4'd4:  pen_r   <= cfg_wdata[NPORT-1:0];
        4'd5:  hcnt_r  <= clamp_cnt(cfg_wdata[CW-1:0]);
        4'd6:  tcnt_r  <= clamp_cnt(cfg_wdata[CW-1:0]);
        4'd8:  hdat_r  <= cfg_wdata;
        4'd9:  hdat_r  <= hdat_r | cfg_wdata;
        4'd10: hdat_r  <= hdat_r & ~cfg_wdata;
        4'd12: tdat_r  <= cfg_wdata;
        4'd13: tdat_r  <= tdat_r | cfg_wdata;
        4'd14: tdat_r  <= tdat_r & ~cfg_wdata;
        default: ;
      endcase
    end
  end

  logic [LW-1:0]    lv_len [NPORT];
  logic [NPORT-1:0] lv_mask;
  for (genvar g = 0; g < NPORT; g++) begin : g_live
    assign lv_len[g]  = (port_len[g*LW +: LW] > LW'(PSW)) ? LW'(PSW) : port_len[g*LW +: LW];
    assign lv_mask[g] = pen_r[g] && (lv_len[g] != '0);
  end

  // frame snapshot
  logic             s_pol, s_dbgen;
  logic [CW-1:0]    s_hcnt, s_tcnt;
  logic [UDW-1:0]   s_hdat, s_tdat;
  logic [DBGW-1:0]  s_dbg;
  logic [HW-1:0]    s_half;
  logic [PSW-1:0]   s_stat [NPORT];
  logic [LW-1:0]    s_len  [NPORT];
  logic [NPORT-1:0] s_mask;

  logic          run, hi;
  logic [2:0]    seg;
  logic [PW-1:0] pidx;
  logic [IW-1:0] bidx;
  logic [HW-1:0] cnt;

  function automatic logic [PW+2:0] seek(input logic [2:0] sg, input logic [PW-1:0] pf,
                                         input logic [CW-1:0] hc, input logic [NPORT-1:0] m,
                                         input logic de, input logic [CW-1:0] tc);
    logic [PW+2:0] r;
    logic hit;
    r = {SEG_LATCH, {PW{1'b0}}};
    hit = 1'b0;
    if (sg == SEG_HEAD && hc != '0) begin r = {SEG_HEAD, {PW{1'b0}}}; hit = 1'b1; end
    if (!hit && sg <= SEG_PORT)
      for (int i = NPORT - 1; i >= 0; i--)
        if (m[i] && (sg == SEG_HEAD || i >= int'(pf))) begin r = {SEG_PORT, PW'(i)}; hit = 1'b1; end
    if (!hit && sg <= SEG_DBG && de) begin r = {SEG_DBG, {PW{1'b0}}}; hit = 1'b1; end
    if (!hit && sg <= SEG_TAIL && tc != '0) r = {SEG_TAIL, {PW{1'b0}}};
    return r;
  endfunction

  logic [CW-1:0]  seg_len;
  logic [PW+2:0]  nxt, first;
  logic           tick, load, cur_bit;
  logic [HW-1:0]  half_live;

  always_comb begin
    case (seg)
      SEG_HEAD: seg_len = s_hcnt;
      SEG_PORT: seg_len = CW'(s_len[pidx]);
      SEG_DBG:  seg_len = CW'(DBGW);
      SEG_TAIL: seg_len = s_tcnt;
      default:  seg_len = '0;
    endcase
    case (seg)
      SEG_HEAD: nxt = seek(SEG_PORT, '0, s_hcnt, s_mask, s_dbgen, s_tcnt);
      SEG_PORT: nxt = (pidx == PW'(NPORT - 1)) ? seek(SEG_DBG, '0, s_hcnt, s_mask, s_dbgen, s_tcnt)
                                               : seek(SEG_PORT, pidx + 1'b1, s_hcnt, s_mask, s_dbgen, s_tcnt);
      SEG_DBG:  nxt = seek(SEG_TAIL, '0, s_hcnt, s_mask, s_dbgen, s_tcnt);
      default:  nxt = {SEG_LATCH, {PW{1'b0}}};
    endcase
    case (seg)
      SEG_HEAD: cur_bit = s_hdat[bidx];
      SEG_PORT: cur_bit = s_stat[pidx][bidx[LW-1:0]];
      SEG_DBG:  cur_bit = s_dbg[bidx];
      SEG_TAIL: cur_bit = s_tdat[bidx];
      default:  cur_bit = 1'b0;
    endcase
  end

  assign first     = seek(SEG_HEAD, '0, hcnt_r, lv_mask, dbgen_r, tcnt_r);
  assign half_live = HW'(phase_r == '0 ? PHW'(1) : phase_r) * HW'(UNIT);
  assign tick      = (cnt == s_half - 1'b1);
  assign load      = en_r && (!run || (tick && hi && seg == SEG_LATCH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; hi <= 1'b0; cnt <= '0; seg <= SEG_HEAD; pidx <= '0; bidx <= '0;
      s_pol <= 1'b0; s_dbgen <= 1'b0; s_hcnt <= '0; s_tcnt <= '0; s_hdat <= '0;
      s_tdat <= '0; s_dbg <= '0; s_half <= HW'(1); s_mask <= '0;
      for (int i = 0; i < NPORT; i++) begin s_stat[i] <= '0; s_len[i] <= '0; end
    end else if (load) begin
      run <= 1'b1; hi <= 1'b0; cnt <= '0;
      {seg, pidx} <= first; bidx <= '0;
      s_pol <= pol_r; s_dbgen <= dbgen_r; s_hcnt <= hcnt_r; s_tcnt <= tcnt_r;
      s_hdat <= hdat_r; s_tdat <= tdat_r; s_dbg <= dbg_word; s_half <= half_live;
      s_mask <= lv_mask;
      for (int i = 0; i < NPORT; i++) begin
        s_stat[i] <= port_stat[i*PSW +: PSW];
        s_len[i]  <= lv_len[i];
      end
    end else if (!en_r) begin
      run <= 1'b0; hi <= 1'b0; cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
      hi  <= !hi;
      if (hi) begin
        if (CW'(bidx) + 1'b1 < seg_len) bidx <= bidx + 1'b1;
        else begin {seg, pidx} <= nxt; bidx <= '0; end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign led_sclk  = run && hi && (seg != SEG_LATCH);
  assign led_latch = run && (seg == SEG_LATCH);
  assign led_sdata = run ? (cur_bit ^ s_pol) : pol_r;

  AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    led_latch |-> !led_sclk); // R10
  AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(led_sdata)) |-> ($fell(led_sclk) || $fell(led_latch))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_r |=> (!led_sclk && !led_latch)); // R11
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < s_half)); // R1
  AST_HEAD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && seg == SEG_HEAD) |-> (CW'(bidx) < s_hcnt && s_hcnt <= CW'(UDW))); // R4
  AST_DBG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && seg == SEG_DBG) |-> s_dbgen); // R5
endmodule

// File: tb/led_chain_ctrl_bench.sv
module led_chain_ctrl_bench;
  localparam int UNIT = 2;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [47:0] port_stat = '0;
  logic [23:0] port_len = '0;
  logic [16:0] dbg_word = '0;
  logic led_sclk, led_sdata, led_latch;

  led_chain_ctrl #(.UNIT(UNIT)) u_led_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .port_stat(port_stat), .port_len(port_len), .dbg_word(dbg_word),
    .led_sclk(led_sclk), .led_sdata(led_sdata), .led_latch(led_latch));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int b_hc, b_tc;
  logic [31:0] b_hdat, b_tdat;
  logic [7:0]  b_pen;
  logic [5:0]  b_stat [8];
  int          b_len  [8];
  logic        b_dbgen, b_pol;
  logic [16:0] b_dbg;
  logic exp_b [0:255];
  logic got_b [0:255];
  int exp_n, got_n;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, expv); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic apply_ports();
    for (int p = 0; p < 8; p++) begin
      port_stat[p*6 +: 6] = b_stat[p];
      port_len[p*3 +: 3]  = 3'(b_len[p]);
    end
    dbg_word = b_dbg;
  endtask

  task automatic push(input logic v);
    exp_b[exp_n] = v ^ b_pol; exp_n++;
  endtask

  task automatic build_exp();
    int hc, tc, l;
    exp_n = 0;
    hc = b_hc > 32 ? 32 : b_hc;
    tc = b_tc > 32 ? 32 : b_tc;
    for (int i = 0; i < hc; i++) push(b_hdat[i]);
    for (int p = 0; p < 8; p++)
      if (b_pen[p]) begin
        l = b_len[p] > 6 ? 6 : b_len[p];
        for (int i = 0; i < l; i++) push(b_stat[p][i]);
      end
    if (b_dbgen) for (int i = 0; i < 17; i++) push(b_dbg[i]);
    for (int i = 0; i < tc; i++) push(b_tdat[i]);
  endtask

  task automatic sync_frame();
    @(negedge clk);
    while (!led_latch) @(negedge clk);
    while (led_latch) @(negedge clk);
  endtask

  task automatic grab();
    logic prev;
    bit done;
    prev = 1'b0; done = 1'b0; got_n = 0;
    while (!done) begin
      @(negedge clk);
      if (led_latch) done = 1'b1;
      else begin
        if (led_sclk && !prev && got_n < 256) begin got_b[got_n] = led_sdata; got_n++; end
        prev = led_sclk;
      end
    end
  endtask

  task automatic check_frame(input string tag);
    int bad;
    bad = -1;
    if (got_n == exp_n)
      for (int i = exp_n - 1; i >= 0; i--) if (got_b[i] !== exp_b[i]) bad = i;
    if (got_n != exp_n) check(1'b0, {tag, " frame length"}, got_n, exp_n);
    else if (bad >= 0) check(1'b0, $sformatf("%s bit %0d", tag, bad), int'(got_b[bad]), int'(exp_b[bad]));
    else check(1'b1, tag, 0, 0);
  endtask

  task automatic meas_high(output int w);
    @(negedge clk);
    while (led_sclk) @(negedge clk);
    while (!led_sclk) @(negedge clk);
    w = 0;
    while (led_sclk) begin w++; @(negedge clk); end
  endtask

  task automatic write_all();
    wr(4'd5, 32'(b_hc)); wr(4'd6, 32'(b_tc));
    wr(4'd8, b_hdat); wr(4'd12, b_tdat);
    wr(4'd4, {24'd0, b_pen}); wr(4'd3, {31'd0, b_dbgen}); wr(4'd2, {31'd0, b_pol});
    apply_ports();
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check(!led_sclk && !led_latch && !led_sdata, "R11 reset outputs", {led_sclk, led_latch, led_sdata}, 0);
    rst_n = 1'b1;
    b_hc = 5; b_tc = 3; b_hdat = 32'h0000_0016; b_tdat = 32'h5; b_pen = 8'h00;
    for (int p = 0; p < 8; p++) begin b_stat[p] = '0; b_len[p] = 0; end
    b_dbgen = 1'b0; b_pol = 1'b0; b_dbg = '0;
    write_all();
    wr(4'd0, 32'd1);
    build_exp(); grab(); check_frame("R2 R3 first frame after enable");
    meas_high(w); check(w == 4 * UNIT, "R1 reset phase half period", w, 4 * UNIT);
    @(negedge clk); while (!led_latch) @(negedge clk);
    w = 0; while (led_latch) begin w++; @(negedge clk); end
    check(w == 8 * UNIT, "R10 latch width", w, 8 * UNIT);
    wr(4'd1, 32'd0); sync_frame(); meas_high(w);
    check(w == UNIT, "R1 phase zero acts as one", w, UNIT);
    wr(4'd1, 32'd1);

    for (int k = 0; k < 12; k++) begin
      b_hc = (k * 11) % 41; b_tc = (k * 7 + 2) % 37;
      b_hdat = 32'(k) * 32'h9E37_79B9; b_tdat = ~(32'(k) * 32'h0101_3C5A);
      b_pen = 8'(k * 53 + 1);
      for (int p = 0; p < 8; p++) begin b_len[p] = (k + p) % 8; b_stat[p] = 6'(k * 13 + p * 7 + 5); end
      b_dbgen = k[0]; b_pol = k[1]; b_dbg = 17'(k * 4099 + 77);
      write_all(); build_exp(); sync_frame(); grab();
      check_frame($sformatf("R3 R4 R5 R6 sweep %0d", k));
    end

    b_pol = 1'b0; b_hc = 32; b_tc = 0; b_pen = 8'h00; b_dbgen = 1'b0;
    write_all();
    wr(4'd8, 32'hF0F0_0F0F); wr(4'd9, 32'h0000_00F0); wr(4'd10, 32'h0F00_000F);
    wr(4'd7, 32'hFFFF_FFFF); wr(4'd15, 32'hFFFF_FFFF); wr(4'd11, 32'h1234_5678);
    b_hdat = (32'hF0F0_0F0F | 32'h0000_00F0) & ~32'h0F00_000F;
    build_exp(); sync_frame(); grab(); check_frame("R7 R8 set clear and unmapped writes");

    b_hc = 20; b_tc = 4; b_pen = 8'h81; b_len[0] = 3; b_len[7] = 6;
    write_all(); build_exp(); sync_frame();
    fork
      grab();
      begin repeat (30) @(negedge clk); wr(4'd5, 32'd2); end
    join
    check_frame("R9 mid-frame change ignored");
    b_hc = 2;

    wr(4'd1, 32'd3); sync_frame(); meas_high(w);
    check(w == 3 * UNIT, "R1 phase three half period", w, 3 * UNIT);

    wr(4'd2, 32'd1); wr(4'd0, 32'd0);
    repeat (2) @(negedge clk);
    w = 0;
    for (int i = 0; i < 60; i++) begin
      if (led_sclk || led_latch || !led_sdata) w++;
      @(negedge clk);
    end
    check(w == 0, "R11 disabled holds idle", w, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule